// File: doc/BRIEF.md
# Command and Interrupt Mask Register

This block is the 32-bit command word of a network controller's host interface. The host writes it through a simple write port with byte enables. The low byte carries two action fields, one for the command unit and one for the receive unit. Each field stays visible to that unit's engine until the engine signals that it has taken the command. The device then clears the field, so the host never has to.

The upper byte controls interrupts. It holds one mask bit for each of six device events, a fire-once software interrupt bit, and a global mask. Each event pulse latches a pending flag, and the host clears that flag through an acknowledge input. The active-low interrupt pin asserts when an unmasked flag is pending, or when a software request is pending, provided the global mask is clear. The global mask overrides everything else.

Top module: `nic_cmd_irq_reg`

## Requirements
- R1: After reset, `rd_data` reads 0, `cu_cmd` and `ru_cmd` are 0, and `int_n` is 1.
- R2: An event pulse on `evt_in[i]` sets that event's pending flag. If mask bit i and the global mask are both 0, `int_n` goes low. With `INT_REG=1`, this happens after the second rising edge that follows the pulse.
- R3: Bit 26+i of the command word masks event i. While its bit is 1, a pending event i does not drive `int_n`, but unmasked pending events still do. Clearing the mask bit exposes an event that is still pending.
- R4: Writing 1 to `evt_ack[i]` clears pending event i. When a pulse and an acknowledge for the same event fall in the same cycle, the flag stays set.
- R5: A write with byte 3 enabled, bit 25 = 1 and bit 24 = 0 latches a software request. The request drives `int_n` low regardless of the per-event masks, and `evt_ack[6]` clears it. Writing 0 to bit 25 does nothing, and bit 25 always reads 0.
- R6: While the global mask (bit 24) is 1, `int_n` stays 1. Requests that are still pending show up again once bit 24 returns to 0.
- R7: A single write that sets both bit 25 and bit 24 creates no request. No interrupt follows after bit 24 is later cleared.
- R8: Bits 7:4 hold the command unit field. It holds its value until a `cu_accept` pulse clears it, and `ru_cmd` is left unchanged.
- R9: Bits 2:0 hold the receive unit field. It holds its value until a `ru_accept` pulse clears it, and `cu_cmd` is left unchanged.
- R10: `wr_be[0]` alone updates the command byte, and `wr_be[3]` alone updates bits 31:24. Bytes 1 and 2 and bit 3 hold nothing and read 0.
- R11: If a write to a field and that unit's accept pulse arrive in the same cycle, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| evt_in | input | NUM_EVT | Event pulses, one per event |
| evt_ack | input | NUM_EVT+1 | Write-one-to-clear for pending events; the top bit clears the software request |
| cu_accept | input | 1 | Command unit has taken its command |
| ru_accept | input | 1 | Receive unit has taken its command |
| cu_cmd | output | CU_W | Command unit action field |
| ru_cmd | output | RU_W | Receive unit action field |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench uses the full six events and the widest action fields (4 and 3 bits), so every mask position and every field bit can be reached. It overrides `INT_REG` to 1, which selects the registered interrupt variant and adds one cycle of pin latency to every interrupt check. Under that option it covers the precedence between the global mask and the software request, mask/unmask with a flag still pending, and races between set and clear on both events and fields.

// File: rtl/nic_cir_pkg.sv
package nic_cir_pkg;
   localparam int REG_W    = 32;
   localparam int BYTE_W   = 8;
   localparam int CMD_BYTE = 0;
   localparam int CTL_BYTE = 3;
   localparam int MASK_LSB = 26;
   localparam int SI_BIT   = 25;
   localparam int GM_BIT   = 24;
   localparam int CU_LSB   = 4;
   localparam int CU_MAX_W = 4;
   localparam int RU_LSB   = 0;
   localparam int RU_MAX_W = 3;
   localparam int MAX_EVT  = REG_W - MASK_LSB;
endpackage

// File: rtl/cir_field.sv
module cir_field #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_stb,
   input  logic [W-1:0] wr_val,
   input  logic         acc,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (wr_stb) q <= wr_val;
      else if (acc)    q <= '0;
   end

   // also covers R9 for the receive unit instance
   p_accept_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !wr_stb |=> q == '0);
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !acc && !wr_stb |=> $stable(q));
   p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> q == $past(wr_val));
endmodule

// File: rtl/cir_evt_bank.sv
module cir_evt_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] ack,
   output logic [N-1:0] pend
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend[i] <= 1'b0;
         else if (evt[i]) pend[i] <= 1'b1;
         else if (ack[i]) pend[i] <= 1'b0;
      end

      p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> pend[i]);
      p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ack[i] && !evt[i] |=> !pend[i]);
   end
endmodule

// File: rtl/cir_irq_out.sv
module cir_irq_out #(
   parameter int N       = 6,
   parameter bit INT_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pend,
   input  logic [N-1:0] mask,
   input  logic         gmask,
   input  logic         swp,
   output logic         int_n
);
   logic want;
   assign want = !gmask && ((|(pend & ~mask)) || swp);

   if (INT_REG) begin : g_reg
      logic int_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) int_q <= 1'b1;
         else        int_q <= !want;
      end
      assign int_n = int_q;

      p_gmask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $past(gmask) |-> int_n);
      p_unmasked_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !gmask && (|(pend & ~mask)) |=> !int_n);
   end else begin : g_comb
      assign int_n = !want;

      p_gmask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         gmask |-> int_n);
      p_unmasked_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !gmask && (|(pend & ~mask)) |-> !int_n);
   end
endmodule

// File: rtl/nic_cmd_irq_reg.sv
module nic_cmd_irq_reg
   import nic_cir_pkg::*;
#(
   parameter int NUM_EVT = 6,
   parameter int CU_W    = 4,
   parameter int RU_W    = 3,
   parameter bit INT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [3:0]         wr_be,
   input  logic [31:0]        wr_data,
   output logic [31:0]        rd_data,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic [NUM_EVT:0]   evt_ack,
   input  logic               cu_accept,
   input  logic               ru_accept,
   output logic [CU_W-1:0]    cu_cmd,
   output logic [RU_W-1:0]    ru_cmd,
   output logic               int_n
);
   localparam int SW_IDX = NUM_EVT;

   initial begin
      assert (NUM_EVT >= 1 && NUM_EVT <= MAX_EVT) else $error("NUM_EVT out of range");
      assert (CU_W >= 1 && CU_W <= CU_MAX_W) else $error("CU_W out of range");
      assert (RU_W >= 1 && RU_W <= RU_MAX_W) else $error("RU_W out of range");
   end

   logic               wr_cmd, wr_ctl;
   logic [NUM_EVT-1:0] mask_q, pend;
   logic               gm_q, swp_q;
   logic               unused_bits;

   assign wr_cmd      = wr_en && wr_be[CMD_BYTE];
   assign wr_ctl      = wr_en && wr_be[CTL_BYTE];
   assign unused_bits = ^{wr_data, wr_be};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         gm_q   <= 1'b0;
      end else if (wr_ctl) begin
         mask_q <= wr_data[MASK_LSB +: NUM_EVT];
         gm_q   <= wr_data[GM_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         swp_q <= 1'b0;
      else if (wr_ctl && wr_data[SI_BIT] && !wr_data[GM_BIT])
         swp_q <= 1'b1;
      else if (evt_ack[SW_IDX])
         swp_q <= 1'b0;
   end

   p_si_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl && wr_data[SI_BIT] && wr_data[GM_BIT] && !swp_q |=> !swp_q);
   p_si_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl && wr_data[SI_BIT] && !wr_data[GM_BIT] |=> swp_q);

   cir_field #(.W(CU_W)) u_cu (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_cmd),
      .wr_val(wr_data[CU_LSB +: CU_W]), .acc(cu_accept), .q(cu_cmd));

   cir_field #(.W(RU_W)) u_ru (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_cmd),
      .wr_val(wr_data[RU_LSB +: RU_W]), .acc(ru_accept), .q(ru_cmd));

   cir_evt_bank #(.N(NUM_EVT)) u_evt (
      .clk(clk), .rst_n(rst_n), .evt(evt_in),
      .ack(evt_ack[NUM_EVT-1:0]), .pend(pend));

   cir_irq_out #(.N(NUM_EVT), .INT_REG(INT_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask_q),
      .gmask(gm_q), .swp(swp_q), .int_n(int_n));

   always_comb begin
      rd_data                      = '0;
      rd_data[MASK_LSB +: NUM_EVT] = mask_q;
      rd_data[GM_BIT]              = gm_q;
      rd_data[CU_LSB +: CU_W]      = cu_cmd;
      rd_data[RU_LSB +: RU_W]      = ru_cmd;
   end
endmodule

// File: tb/nic_cmd_irq_reg_tb_top.sv
`timescale 1ns/1ps
module nic_cmd_irq_reg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_be = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [5:0]  evt_in = '0;
   logic [6:0]  evt_ack = '0;
   logic        cu_accept = 1'b0, ru_accept = 1'b0;
   logic [3:0]  cu_cmd;
   logic [2:0]  ru_cmd;
   logic        int_n;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   nic_cmd_irq_reg #(.NUM_EVT(6), .CU_W(4), .RU_W(3), .INT_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
      .rd_data(rd_data), .evt_in(evt_in), .evt_ack(evt_ack), .cu_accept(cu_accept),
      .ru_accept(ru_accept), .cu_cmd(cu_cmd), .ru_cmd(ru_cmd), .int_n(int_n));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] be, input logic [31:0] d);
      wr_en = 1'b1; wr_be = be; wr_data = d;
      step(1);
      wr_en = 1'b0; wr_be = '0; wr_data = '0;
   endtask

   task automatic pulse(input logic [5:0] e, input logic [6:0] a);
      evt_in = e; evt_ack = a;
      step(1);
      evt_in = '0; evt_ack = '0;
   endtask

   task automatic t_reset();
      chk("R1 rd_data", rd_data, 32'h0);
      chk("R1 cu_cmd", {28'h0, cu_cmd}, 32'h0);
      chk("R1 ru_cmd", {29'h0, ru_cmd}, 32'h0);
      chk("R1 int_n", {31'h0, int_n}, 32'h1);
   endtask

   task automatic t_event();
      pulse(6'b000100, '0); step(1);
      chk("R2 event2 asserts", {31'h0, int_n}, 32'h0);
      pulse('0, 7'b0000100); step(1);
      chk("R4 ack clears", {31'h0, int_n}, 32'h1);
   endtask

   task automatic t_mask();
      wr(4'b1000, 32'h0800_0000);
      chk("R3 mask readback", rd_data, 32'h0800_0000);
      pulse(6'b000010, '0); step(1);
      chk("R3 masked event quiet", {31'h0, int_n}, 32'h1);
      pulse(6'b001000, '0); step(1);
      chk("R3 other event fires", {31'h0, int_n}, 32'h0);
      pulse('0, 7'b0001000); step(1);
      chk("R3 masked pending still quiet", {31'h0, int_n}, 32'h1);
      wr(4'b1000, 32'h0); step(1);
      chk("R3 unmask exposes pending", {31'h0, int_n}, 32'h0);
      pulse('0, 7'b0000010); step(1);
      chk("R3 cleared", {31'h0, int_n}, 32'h1);
   endtask

   task automatic t_race_evt();
      pulse(6'b000001, 7'b0000001); step(1);
      chk("R4 set beats ack", {31'h0, int_n}, 32'h0);
      pulse('0, 7'b0000001); step(1);
      chk("R4 later ack clears", {31'h0, int_n}, 32'h1);
   endtask

   task automatic t_sw();
      wr(4'b1000, 32'hFE00_0000);
      chk("R5 SI reads zero", rd_data, 32'hFC00_0000);
      step(1);
      chk("R5 SI fires under masks", {31'h0, int_n}, 32'h0);
      pulse('0, 7'b1000000); step(1);
      chk("R5 SI ack", {31'h0, int_n}, 32'h1);
      wr(4'b1000, 32'hFC00_0000); step(1);
      chk("R5 SI zero no effect", {31'h0, int_n}, 32'h1);
      wr(4'b1000, 32'h0);
   endtask

   task automatic t_gmask();
      wr(4'b1000, 32'h0100_0000);
      chk("R6 M readback", rd_data, 32'h0100_0000);
      pulse(6'b010000, '0); step(1);
      chk("R6 M blocks", {31'h0, int_n}, 32'h1);
      wr(4'b1000, 32'h0); step(1);
      chk("R6 released", {31'h0, int_n}, 32'h0);
      pulse('0, 7'b0010000); step(1);
      chk("R6 cleared", {31'h0, int_n}, 32'h1);
   endtask

   task automatic t_m_si();
      wr(4'b1000, 32'h0300_0000); step(1);
      chk("R7 M+SI quiet", {31'h0, int_n}, 32'h1);
      wr(4'b1000, 32'h0); step(2);
      chk("R7 SI dropped", {31'h0, int_n}, 32'h1);
   endtask

   task automatic t_cmd();
      wr(4'b0001, 32'h0000_00AD);
      chk("R10 bit3 reads 0", rd_data, 32'h0000_00A5);
      chk("R8 cu held", {28'h0, cu_cmd}, 32'hA);
      cu_accept = 1'b1; step(1); cu_accept = 1'b0;
      chk("R8 cu cleared", {28'h0, cu_cmd}, 32'h0);
      chk("R8 ru untouched", {29'h0, ru_cmd}, 32'h5);
      ru_accept = 1'b1; step(1); ru_accept = 1'b0;
      chk("R9 ru cleared", {29'h0, ru_cmd}, 32'h0);
   endtask

   task automatic t_bytes();
      wr(4'b0001, 32'hFFFF_FF37);
      chk("R10 byte0 only", rd_data, 32'h0000_0037);
      wr(4'b1000, 32'h0800_00FF);
      chk("R10 byte3 only", rd_data, 32'h0800_0037);
      wr(4'b0110, 32'hFFFF_FFFF);
      chk("R10 middle bytes ignored", rd_data, 32'h0800_0037);
      wr(4'b1000, 32'h0);
      cu_accept = 1'b1; ru_accept = 1'b1; step(1);
      cu_accept = 1'b0; ru_accept = 1'b0;
      chk("R9 both cleared", rd_data, 32'h0);
   endtask

   task automatic t_wr_acc();
      cu_accept = 1'b1; ru_accept = 1'b1;
      wr(4'b0001, 32'h0000_0026);
      cu_accept = 1'b0; ru_accept = 1'b0;
      chk("R11 write beats accept", rd_data, 32'h0000_0026);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      step(3);
      t_reset();
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_event();
      t_mask();
      t_race_evt();
      t_sw();
      t_gmask();
      t_m_si();
      t_cmd();
      t_bytes();
      t_wr_acc();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule